// File: doc/BRIEF.md
# Hardware Thread Fork Allocator

This block serves a fork request issued by a running hardware thread context in a small multithreaded core. The request carries a start address and a seed value for the new thread. The block scans the control state of every thread context for a free one that shares the requester's virtual processor. If it finds one, it produces a single set of write strobes. These strobes load that context's restart address and one of its registers, and they seed its status from the requester's privilege mode and address-space identifier. If no context is free, the block raises a thread fault and records exception code 1.

Requests use a valid/ready handshake. An accepted request is evaluated on the following cycle against the per-context inputs present in that cycle. The results appear one clock later as registered outputs. They consist of a one-cycle `done` or `fault` pulse and, on success, a one-hot write enable for the chosen context together with the data to be written. The pipeline, the register file and instruction decode live elsewhere. They consume the write strobes.

Top module: `fork_alloc`

## Requirements
- R1: Only contexts with index 0 through `cfg_last_ctx` (inclusive, so `cfg_last_ctx`+1 contexts) are candidates; contexts above that index are never chosen.
- R2: When several candidates qualify, the lowest index is chosen; `wr_en` has at most one bit set, with bit i meaning context i.
- R3: A context qualifies only when its binding field equals the request's `req_vp`, its `ctx_dyn` bit is 1, its `ctx_halt` bit is 0 and its `ctx_act` bit is 0.
- R4: On success `wr_restart_pc` equals the request's first operand, `wr_dst` equals the request's destination index, and `wr_val` equals the second operand.
- R5: On success the seeded status has run state 0 (running), delay-slot bit 0, dirty bit 1 and activated bit 1.
- R6: On success `wr_ksu` and `wr_asid` equal the requester's mode and address-space identifier.
- R7: When no candidate qualifies, `wr_en` stays 0, `fault` pulses, and `exc_code` becomes 1 and keeps that value until reset.
- R8: A request accepted on edge k completes on edge k+2. Exactly one of `done` (success) or `fault` is high for that single cycle, and both are low in every other cycle.
- R9: `fork_ready` is low in the cycle after acceptance. A request presented while `fork_ready` is low is ignored, including any change to its data.
- R10: While reset is held and after it, `done`, `fault`, `wr_en` and `exc_code` are 0 and `fork_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_last_ctx | input | CIW | Highest context index to scan |
| fork_valid | input | 1 | Fork request present |
| fork_ready | output | 1 | Block can accept a request |
| req_vp | input | VPW | Requester's virtual processor |
| req_ksu | input | 2 | Requester's privilege mode |
| req_asid | input | ASIDW | Requester's address-space identifier |
| req_op1 | input | XLEN | Start address for the new thread |
| req_op2 | input | XLEN | Seed register value |
| req_dst | input | RIDXW | Destination register index |
| ctx_vp | input | NCTX*VPW | Per-context binding, context i in slice i |
| ctx_dyn | input | NCTX | Per-context dynamically-allocatable bit |
| ctx_halt | input | NCTX | Per-context halt bit |
| ctx_act | input | NCTX | Per-context activated bit |
| wr_en | output | NCTX | One-hot write strobe for the chosen context |
| wr_restart_pc | output | XLEN | Restart address to write |
| wr_dst | output | RIDXW | Register index to write |
| wr_val | output | XLEN | Register value to write |
| wr_run_state | output | 2 | Run state to write |
| wr_delay_slot | output | 1 | Delay-slot bit to write |
| wr_dirty | output | 1 | Dirty bit to write |
| wr_active | output | 1 | Activated bit to write |
| wr_ksu | output | 2 | Privilege mode to write |
| wr_asid | output | ASIDW | Address-space identifier to write |
| done | output | 1 | Successful fork pulse |
| fault | output | 1 | Thread fault pulse |
| exc_code | output | 4 | Thread exception code |

## Verification
A wrong qualification or priority bit shows up at the ports on the completion edge as a wrong or extra `wr_en` bit, or as a `fault` where `done` was due. A stale request latch shows up in the written address, value or status fields of that same completion. A stuck sequencing state shows within two cycles of acceptance, either as a missing pulse or as `fork_ready` held low. Sweeping every mix of qualifying and disqualified contexts under every scan limit exposes each of these on the fork that triggers it.

// File: rtl/fork_alloc_pkg.sv
package fork_alloc_pkg;

    localparam int KSU_W = 2;
    localparam int EXC_W = 4;

    localparam logic [EXC_W-1:0] EXC_NONE        = 4'd0;
    localparam logic [EXC_W-1:0] EXC_NO_FREE_CTX = 4'd1;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } fork_state_e;

    // Status bits seeded into a newly started context
    typedef struct packed {
        logic [1:0] run_state;
        logic       delay_slot;
        logic       dirty;
        logic       active;
    } seed_flags_t;

    function automatic seed_flags_t fresh_thread_flags();
        seed_flags_t f;
        f.run_state  = 2'd0;
        f.delay_slot = 1'b0;
        f.dirty      = 1'b1;
        f.active     = 1'b1;
        return f;
    endfunction

    function automatic seed_flags_t cleared_flags();
        seed_flags_t f;
        f = '0;
        return f;
    endfunction

endpackage

// File: rtl/fork_qualify.sv
module fork_qualify #(
    parameter int NCTX = 4,
    parameter int VPW  = 2,
    localparam int CIW = $clog2(NCTX)
) (
    input  logic [CIW-1:0]      cfg_last_ctx,
    input  logic [VPW-1:0]      want_vp,
    input  logic [NCTX*VPW-1:0] ctx_vp,
    input  logic [NCTX-1:0]     ctx_dyn,
    input  logic [NCTX-1:0]     ctx_halt,
    input  logic [NCTX-1:0]     ctx_act,
    output logic [NCTX-1:0]     eligible
);

    for (genvar i = 0; i < NCTX; i++) begin : g_ctx
        localparam logic [CIW-1:0] IDX = CIW'(i);
        logic in_window;
        logic same_vp;
        logic is_free;

        assign in_window   = (IDX <= cfg_last_ctx);
        assign same_vp     = (ctx_vp[i*VPW +: VPW] == want_vp);
        assign is_free     = ctx_dyn[i] & ~ctx_halt[i] & ~ctx_act[i];
        assign eligible[i] = in_window & same_vp & is_free;
    end

endmodule

// File: rtl/fork_pick.sv
module fork_pick #(
    parameter int NCTX = 4
) (
    input  logic [NCTX-1:0] eligible,
    output logic [NCTX-1:0] pick_onehot,
    output logic            pick_found
);

    logic taken;

    always_comb begin
        pick_onehot = '0;
        taken       = 1'b0;
        for (int i = 0; i < NCTX; i++) begin
            if (eligible[i] && !taken) begin
                pick_onehot[i] = 1'b1;
                taken          = 1'b1;
            end
        end
    end

    assign pick_found = taken;

endmodule

// File: rtl/fork_seq.sv
module fork_seq
    import fork_alloc_pkg::*;
#(
    parameter int VPW   = 2,
    parameter int ASIDW = 8,
    parameter int XLEN  = 32,
    parameter int RIDXW = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fork_valid,
    output logic             fork_ready,
    input  logic [VPW-1:0]   req_vp,
    input  logic [KSU_W-1:0] req_ksu,
    input  logic [ASIDW-1:0] req_asid,
    input  logic [XLEN-1:0]  req_op1,
    input  logic [XLEN-1:0]  req_op2,
    input  logic [RIDXW-1:0] req_dst,
    output logic             busy,
    output logic [VPW-1:0]   hold_vp,
    output logic [KSU_W-1:0] hold_ksu,
    output logic [ASIDW-1:0] hold_asid,
    output logic [XLEN-1:0]  hold_op1,
    output logic [XLEN-1:0]  hold_op2,
    output logic [RIDXW-1:0] hold_dst
);

    fork_state_e state_q;
    logic        accept;

    assign fork_ready = (state_q == ST_IDLE);
    assign busy       = (state_q == ST_BUSY);
    assign accept     = fork_valid & fork_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else if (accept) begin
            state_q <= ST_BUSY;
        end else if (busy) begin
            state_q <= ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_vp   <= '0;
            hold_ksu  <= '0;
            hold_asid <= '0;
            hold_op1  <= '0;
            hold_op2  <= '0;
            hold_dst  <= '0;
        end else if (accept) begin
            hold_vp   <= req_vp;
            hold_ksu  <= req_ksu;
            hold_asid <= req_asid;
            hold_op1  <= req_op1;
            hold_op2  <= req_op2;
            hold_dst  <= req_dst;
        end
    end

endmodule

// File: rtl/fork_alloc.sv
module fork_alloc
    import fork_alloc_pkg::*;
#(
    parameter int NCTX  = 4,
    parameter int VPW   = 2,
    parameter int ASIDW = 8,
    parameter int XLEN  = 32,
    parameter int RIDXW = 5,
    localparam int CIW  = $clog2(NCTX)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CIW-1:0]      cfg_last_ctx,
    input  logic                fork_valid,
    output logic                fork_ready,
    input  logic [VPW-1:0]      req_vp,
    input  logic [KSU_W-1:0]    req_ksu,
    input  logic [ASIDW-1:0]    req_asid,
    input  logic [XLEN-1:0]     req_op1,
    input  logic [XLEN-1:0]     req_op2,
    input  logic [RIDXW-1:0]    req_dst,
    input  logic [NCTX*VPW-1:0] ctx_vp,
    input  logic [NCTX-1:0]     ctx_dyn,
    input  logic [NCTX-1:0]     ctx_halt,
    input  logic [NCTX-1:0]     ctx_act,
    output logic [NCTX-1:0]     wr_en,
    output logic [XLEN-1:0]     wr_restart_pc,
    output logic [RIDXW-1:0]    wr_dst,
    output logic [XLEN-1:0]     wr_val,
    output logic [1:0]          wr_run_state,
    output logic                wr_delay_slot,
    output logic                wr_dirty,
    output logic                wr_active,
    output logic [KSU_W-1:0]    wr_ksu,
    output logic [ASIDW-1:0]    wr_asid,
    output logic                done,
    output logic                fault,
    output logic [EXC_W-1:0]    exc_code
);

    logic             busy;
    logic [VPW-1:0]   hold_vp;
    logic [KSU_W-1:0] hold_ksu;
    logic [ASIDW-1:0] hold_asid;
    logic [XLEN-1:0]  hold_op1;
    logic [XLEN-1:0]  hold_op2;
    logic [RIDXW-1:0] hold_dst;
    logic [NCTX-1:0]  eligible;
    logic [NCTX-1:0]  pick_onehot;
    logic             pick_found;
    seed_flags_t      flags_q;

    fork_seq #(
        .VPW  (VPW),
        .ASIDW(ASIDW),
        .XLEN (XLEN),
        .RIDXW(RIDXW)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .fork_valid(fork_valid),
        .fork_ready(fork_ready),
        .req_vp    (req_vp),
        .req_ksu   (req_ksu),
        .req_asid  (req_asid),
        .req_op1   (req_op1),
        .req_op2   (req_op2),
        .req_dst   (req_dst),
        .busy      (busy),
        .hold_vp   (hold_vp),
        .hold_ksu  (hold_ksu),
        .hold_asid (hold_asid),
        .hold_op1  (hold_op1),
        .hold_op2  (hold_op2),
        .hold_dst  (hold_dst)
    );

    fork_qualify #(
        .NCTX(NCTX),
        .VPW (VPW)
    ) u_qual (
        .cfg_last_ctx(cfg_last_ctx),
        .want_vp     (hold_vp),
        .ctx_vp      (ctx_vp),
        .ctx_dyn     (ctx_dyn),
        .ctx_halt    (ctx_halt),
        .ctx_act     (ctx_act),
        .eligible    (eligible)
    );

    fork_pick #(
        .NCTX(NCTX)
    ) u_pick (
        .eligible   (eligible),
        .pick_onehot(pick_onehot),
        .pick_found (pick_found)
    );

    // Completion pulses and strobes
    always_ff @(posedge clk) begin
        if (rst) begin
            done     <= 1'b0;
            fault    <= 1'b0;
            wr_en    <= '0;
            exc_code <= EXC_NONE;
        end else if (busy) begin
            done  <= pick_found;
            fault <= ~pick_found;
            wr_en <= pick_onehot;
            if (!pick_found) begin
                exc_code <= EXC_NO_FREE_CTX;
            end
        end else begin
            done  <= 1'b0;
            fault <= 1'b0;
            wr_en <= '0;
        end
    end

    // Write data, loaded only on a successful completion
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_restart_pc <= '0;
            wr_dst        <= '0;
            wr_val        <= '0;
            wr_ksu        <= '0;
            wr_asid       <= '0;
            flags_q       <= cleared_flags();
        end else if (busy && pick_found) begin
            wr_restart_pc <= hold_op1;
            wr_dst        <= hold_dst;
            wr_val        <= hold_op2;
            wr_ksu        <= hold_ksu;
            wr_asid       <= hold_asid;
            flags_q       <= fresh_thread_flags();
        end
    end

    assign wr_run_state  = flags_q.run_state;
    assign wr_delay_slot = flags_q.delay_slot;
    assign wr_dirty      = flags_q.dirty;
    assign wr_active     = flags_q.active;

endmodule

// File: rtl/fork_alloc_chk.sv
module fork_alloc_chk
    import fork_alloc_pkg::*;
#(
    parameter int NCTX = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             fork_valid,
    input logic             fork_ready,
    input logic [NCTX-1:0]  ctx_dyn,
    input logic [NCTX-1:0]  ctx_halt,
    input logic [NCTX-1:0]  ctx_act,
    input logic [NCTX-1:0]  wr_en,
    input logic             done,
    input logic             fault,
    input logic [EXC_W-1:0] exc_code
);

    logic accept;
    assign accept = fork_valid & fork_ready;

    // R2
    wr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_en));

    // R8
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && fault));

    // R8
    done_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (wr_en != '0));

    // R7
    fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        fault |-> (wr_en == '0 && exc_code == EXC_NO_FREE_CTX));

    // R9
    busy_block_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !fork_ready);

    // R8
    completes_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> ##1 (done || fault));

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3
    free_only_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ((wr_en & ~$past(ctx_dyn & ~ctx_halt & ~ctx_act)) == '0));

endmodule

bind fork_alloc fork_alloc_chk #(.NCTX(NCTX)) u_fork_alloc_chk (
    .clk       (clk),
    .rst       (rst),
    .fork_valid(fork_valid),
    .fork_ready(fork_ready),
    .ctx_dyn   (ctx_dyn),
    .ctx_halt  (ctx_halt),
    .ctx_act   (ctx_act),
    .wr_en     (wr_en),
    .done      (done),
    .fault     (fault),
    .exc_code  (exc_code)
);

// File: tb/tb_fork_alloc.sv
`timescale 1ns/1ps
module tb_fork_alloc;

    localparam int NCTX  = 4;
    localparam int VPW   = 2;
    localparam int ASIDW = 8;
    localparam int XLEN  = 32;
    localparam int RIDXW = 5;
    localparam int CIW   = $clog2(NCTX);

    logic                clk = 1'b0;
    logic                rst;
    logic [CIW-1:0]      cfg_last_ctx;
    logic                fork_valid;
    logic                fork_ready;
    logic [VPW-1:0]      req_vp;
    logic [1:0]          req_ksu;
    logic [ASIDW-1:0]    req_asid;
    logic [XLEN-1:0]     req_op1;
    logic [XLEN-1:0]     req_op2;
    logic [RIDXW-1:0]    req_dst;
    logic [NCTX*VPW-1:0] ctx_vp;
    logic [NCTX-1:0]     ctx_dyn;
    logic [NCTX-1:0]     ctx_halt;
    logic [NCTX-1:0]     ctx_act;
    logic [NCTX-1:0]     wr_en;
    logic [XLEN-1:0]     wr_restart_pc;
    logic [RIDXW-1:0]    wr_dst;
    logic [XLEN-1:0]     wr_val;
    logic [1:0]          wr_run_state;
    logic                wr_delay_slot;
    logic                wr_dirty;
    logic                wr_active;
    logic [1:0]          wr_ksu;
    logic [ASIDW-1:0]    wr_asid;
    logic                done;
    logic                fault;
    logic [3:0]          exc_code;

    int checks = 0;
    int errors = 0;
    logic sticky_exc = 1'b0;
    logic finished = 1'b0;

    always #2 clk = ~clk;

    fork_alloc #(
        .NCTX(NCTX), .VPW(VPW), .ASIDW(ASIDW), .XLEN(XLEN), .RIDXW(RIDXW)
    ) dut (
        .clk(clk), .rst(rst), .cfg_last_ctx(cfg_last_ctx),
        .fork_valid(fork_valid), .fork_ready(fork_ready),
        .req_vp(req_vp), .req_ksu(req_ksu), .req_asid(req_asid),
        .req_op1(req_op1), .req_op2(req_op2), .req_dst(req_dst),
        .ctx_vp(ctx_vp), .ctx_dyn(ctx_dyn), .ctx_halt(ctx_halt), .ctx_act(ctx_act),
        .wr_en(wr_en), .wr_restart_pc(wr_restart_pc), .wr_dst(wr_dst), .wr_val(wr_val),
        .wr_run_state(wr_run_state), .wr_delay_slot(wr_delay_slot),
        .wr_dirty(wr_dirty), .wr_active(wr_active),
        .wr_ksu(wr_ksu), .wr_asid(wr_asid),
        .done(done), .fault(fault), .exc_code(exc_code)
    );

    task automatic check(input logic ok, input string tag,
                         input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One fork: accept on the first edge, completion on the second, sample after it
    task automatic run_fork();
        @(negedge clk);
        fork_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        fork_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst          = 1'b1;
        fork_valid   = 1'b0;
        cfg_last_ctx = '0;
        req_vp       = 2'd1;
        req_ksu      = '0;
        req_asid     = '0;
        req_op1      = '0;
        req_op2      = '0;
        req_dst      = '0;
        ctx_vp       = '0;
        ctx_dyn      = '0;
        ctx_halt     = '0;
        ctx_act      = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 values while reset is held
        check(done == 1'b0 && fault == 1'b0, "R10 pulses in reset", {done, fault}, 0);
        check(wr_en == '0, "R10 wr_en in reset", wr_en, 0);
        check(exc_code == 4'd0, "R10 exc_code in reset", exc_code, 0);
        rst = 1'b0;
        @(negedge clk);
        check(fork_ready == 1'b1, "R10 ready after reset", fork_ready, 1);
        check(exc_code == 4'd0, "R10 exc_code after reset", exc_code, 0);

        // Sweep every scan limit and every mix of context states.
        // Per-context code: 0 free, 1 other binding, 2 halted, 3 not allocatable or already active
        for (int cfg = 0; cfg < NCTX; cfg++) begin
            for (int pat = 0; pat < 256; pat++) begin
                int exp_idx;
                logic [NCTX-1:0] exp_en;
                int n;
                n = cfg * 256 + pat;
                cfg_last_ctx = CIW'(cfg);
                req_vp   = 2'd1;
                req_ksu  = 2'(n);
                req_asid = ASIDW'(n * 7 + 3);
                req_op1  = XLEN'(32'h4000_0000 + n * 16);
                req_op2  = XLEN'(32'hA5A5_0000 ^ n);
                req_dst  = RIDXW'(n + 1);
                exp_idx  = -1;
                for (int i = 0; i < NCTX; i++) begin
                    int c;
                    c = (pat >> (2 * i)) & 3;
                    ctx_vp[i*VPW +: VPW] = (c == 1) ? 2'd2 : 2'd1;
                    ctx_halt[i] = (c == 2);
                    ctx_dyn[i]  = !(c == 3 && ((n + i) % 2 == 0));
                    ctx_act[i]  = (c == 3 && ((n + i) % 2 == 1));
                    if (c == 0 && i <= cfg && exp_idx < 0) exp_idx = i;
                end
                exp_en = (exp_idx >= 0) ? NCTX'(1 << exp_idx) : '0;
                run_fork();
                // R1 R2 R3 chosen context
                check(wr_en == exp_en, "R1/R2/R3 wr_en", wr_en, exp_en);
                if (exp_idx >= 0) begin
                    check(done == 1'b1 && fault == 1'b0, "R8 done pulse", {done, fault}, 2);
                    // R4
                    check(wr_restart_pc == req_op1 && wr_val == req_op2 && wr_dst == req_dst,
                          "R4 written data", wr_restart_pc, req_op1);
                    // R5
                    check(wr_run_state == 2'd0 && !wr_delay_slot && wr_dirty && wr_active,
                          "R5 status seed", {wr_run_state, wr_delay_slot, wr_dirty, wr_active}, 5'b00011);
                    // R6
                    check(wr_ksu == req_ksu && wr_asid == req_asid, "R6 mode and asid",
                          {wr_ksu, wr_asid}, {req_ksu, req_asid});
                end else begin
                    sticky_exc = 1'b1;
                    check(fault == 1'b1 && done == 1'b0, "R7 fault pulse", {done, fault}, 1);
                end
                // R7 sticky exception code
                check(exc_code == (sticky_exc ? 4'd1 : 4'd0), "R7 exc_code", exc_code,
                      sticky_exc ? 1 : 0);
                check(fork_ready == 1'b1, "R9 ready after completion", fork_ready, 1);
            end
        end

        // R9: a request held during the busy cycle with new data is ignored
        cfg_last_ctx = CIW'(NCTX - 1);
        for (int i = 0; i < NCTX; i++) begin
            ctx_vp[i*VPW +: VPW] = 2'd1;
        end
        ctx_dyn  = '1;
        ctx_halt = '0;
        ctx_act  = '0;
        @(negedge clk);
        req_op1    = 32'h1111_0000;
        fork_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(fork_ready == 1'b0, "R9 ready low while busy", fork_ready, 0);
        req_op1 = 32'h2222_0000;
        @(posedge clk);
        @(negedge clk);
        fork_valid = 1'b0;
        check(done == 1'b1 && wr_restart_pc == 32'h1111_0000, "R9 first request kept",
              wr_restart_pc, 32'h1111_0000);
        @(posedge clk);
        @(negedge clk);
        check(done == 1'b0 && fault == 1'b0, "R8 R9 no second completion", {done, fault}, 0);
        @(posedge clk);
        @(negedge clk);
        check(done == 1'b0 && fault == 1'b0 && wr_en == '0, "R8 quiet when idle",
              {done, fault}, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule